// File: doc/BRIEF.md
# Queue Depth Histogram Scorer

This block watches the fill levels of four queues and builds a picture of how deep they run together. Each time a sample strobe is raised it takes the mean of the four occupancy values, maps that mean onto one of sixteen histogram bins, and counts it there. A stimulus-tuning flow uses the resulting histogram to judge whether its traffic drives the queues into their deep, rarely visited states.

Alongside the histogram the block keeps a running score in which each bin contributes its count times a weight that rises linearly with depth. The weights run from 0.1 for the shallowest bin to 1.6 for the deepest. They are held as the integers 1 to 16, so the score is an integer in tenths. A synchronous clear empties the histogram and the score. Bin counts are read one at a time through an index port.

Top module: `qdepth_hist_scorer`

## Requirements
- R1: After reset every bin count and the score read zero.
- R2: The `occ` input packs queue q into bits [5q+4:5q]. On a strobe the selected bin is (occ0+occ1+occ2+occ3) divided by four and rounded down, for results 0 to 15.
- R3: When that mean exceeds 15 the top bin, index 15, is selected.
- R4: A strobe without clear adds one to the selected bin at the next rising clock edge and leaves every other bin unchanged.
- R5: At that same edge the score grows by the selected bin index plus one, in units of 0.1.
- R6: With neither strobe nor clear asserted, no bin count and no score changes, whatever the occupancy inputs do.
- R7: A bin count that has reached 2^BIN_W-1 stays there on further strobes to that bin.
- R8: The score saturates at 2^SCORE_W-1 instead of wrapping.
- R9: Clear zeroes all bins and the score at the next rising edge, and takes priority over a strobe in the same cycle.
- R10: `rd_count` presents the count of bin `rd_idx` combinationally, without a clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| occ | input | NUM_Q*DEPTH_W (20) | Packed occupancy of the four queues, queue 0 in the low bits |
| sample | input | 1 | Sample strobe: bin the current mean depth |
| clear | input | 1 | Empty histogram and score at the next edge |
| rd_idx | input | IDX_W (4) | Bin to present on rd_count |
| rd_count | output | BIN_W (16) | Count held in bin rd_idx |
| score | output | SCORE_W (24) | Weighted score, one unit is 0.1 |

## Verification
The histogram and the score are both due at the first rising edge after a strobe or a clear, and the bin read port answers in the same cycle as its index changes. The bench drives each strobe at a falling edge, withdraws it at the next falling edge, and only then queues the expected values, so every comparison falls half a cycle after the edge that updated the state. The monitor sets the read index and samples one time unit later, while no strobe is active, so reads never straddle an update. The bench shrinks BIN_W and SCORE_W so both saturation limits are reached in a few hundred cycles.

// File: rtl/qdh_pkg.sv
package qdh_pkg;

    // Default geometry of the scorer
    localparam int unsigned QDH_NUM_Q    = 4;
    localparam int unsigned QDH_DEPTH_W  = 5;
    localparam int unsigned QDH_NUM_BINS = 16;
    localparam int unsigned QDH_BIN_W    = 16;
    localparam int unsigned QDH_SCORE_W  = 24;

endpackage

// File: rtl/qdh_avg_binner.sv
module qdh_avg_binner #(
    parameter int unsigned NUM_Q    = qdh_pkg::QDH_NUM_Q,
    parameter int unsigned DEPTH_W  = qdh_pkg::QDH_DEPTH_W,
    parameter int unsigned NUM_BINS = qdh_pkg::QDH_NUM_BINS,
    localparam int unsigned IDX_W   = $clog2(NUM_BINS)
) (
    input  logic [NUM_Q*DEPTH_W-1:0] occ,
    output logic [IDX_W-1:0]         bin_idx
);
    localparam int unsigned SHIFT = $clog2(NUM_Q);
    localparam int unsigned SUM_W = DEPTH_W + SHIFT;
    localparam logic [SUM_W-1:0] TOP_BIN = SUM_W'(NUM_BINS - 1);

    logic [SUM_W-1:0] part [NUM_Q+1];
    logic [SUM_W-1:0] mean_w;

    assign part[0] = '0;

    // Adder chain over the queue fields
    for (genvar q = 0; q < NUM_Q; q++) begin : g_sum
        assign part[q+1] = part[q] + SUM_W'(occ[q*DEPTH_W +: DEPTH_W]);
    end

    always_comb begin
        mean_w = part[NUM_Q] >> SHIFT;
        if (mean_w > TOP_BIN) begin
            bin_idx = IDX_W'(NUM_BINS - 1);
        end else begin
            bin_idx = IDX_W'(mean_w);
        end
    end

endmodule

// File: rtl/qdh_bin_bank.sv
module qdh_bin_bank #(
    parameter int unsigned NUM_BINS = qdh_pkg::QDH_NUM_BINS,
    parameter int unsigned BIN_W    = qdh_pkg::QDH_BIN_W,
    localparam int unsigned IDX_W   = $clog2(NUM_BINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic [IDX_W-1:0] inc_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [BIN_W-1:0] rd_count
);
    localparam logic [BIN_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [NUM_BINS-1:0][BIN_W-1:0] cnt;
    } bank_t;

    bank_t st_d, st_q;
    logic [NUM_BINS-1:0] hit;

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_hit
        assign hit[b] = inc && (inc_idx == IDX_W'(b));
    end

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else begin
            for (int b = 0; b < NUM_BINS; b++) begin
                if (hit[b] && (st_q.cnt[b] != CNT_MAX)) begin
                    st_d.cnt[b] = st_q.cnt[b] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_count = st_q.cnt[rd_idx];

endmodule

// File: rtl/qdh_score_acc.sv
module qdh_score_acc #(
    parameter int unsigned NUM_BINS = qdh_pkg::QDH_NUM_BINS,
    parameter int unsigned SCORE_W  = qdh_pkg::QDH_SCORE_W,
    localparam int unsigned IDX_W   = $clog2(NUM_BINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               add,
    input  logic [IDX_W-1:0]   add_idx,
    output logic [SCORE_W-1:0] score
);
    typedef struct packed {
        logic [SCORE_W-1:0] score;
    } acc_t;

    acc_t st_d, st_q;
    logic [SCORE_W:0] sum_w;

    always_comb begin
        st_d  = st_q;
        // weight of bin i is i+1 tenths
        sum_w = {1'b0, st_q.score} + (SCORE_W+1)'(add_idx) + (SCORE_W+1)'(1);
        if (clear) begin
            st_d.score = '0;
        end else if (add) begin
            if (sum_w[SCORE_W]) begin
                st_d.score = '1;
            end else begin
                st_d.score = sum_w[SCORE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign score = st_q.score;

endmodule

// File: rtl/qdepth_hist_scorer.sv
module qdepth_hist_scorer #(
    parameter int unsigned NUM_Q    = qdh_pkg::QDH_NUM_Q,
    parameter int unsigned DEPTH_W  = qdh_pkg::QDH_DEPTH_W,
    parameter int unsigned NUM_BINS = qdh_pkg::QDH_NUM_BINS,
    parameter int unsigned BIN_W    = qdh_pkg::QDH_BIN_W,
    parameter int unsigned SCORE_W  = qdh_pkg::QDH_SCORE_W,
    localparam int unsigned IDX_W   = $clog2(NUM_BINS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_Q*DEPTH_W-1:0] occ,
    input  logic                     sample,
    input  logic                     clear,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [BIN_W-1:0]         rd_count,
    output logic [SCORE_W-1:0]       score
);
    logic [IDX_W-1:0] sel_bin;

    qdh_avg_binner #(
        .NUM_Q    (NUM_Q),
        .DEPTH_W  (DEPTH_W),
        .NUM_BINS (NUM_BINS)
    ) u_binner (
        .occ     (occ),
        .bin_idx (sel_bin)
    );

    qdh_bin_bank #(
        .NUM_BINS (NUM_BINS),
        .BIN_W    (BIN_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .inc      (sample),
        .inc_idx  (sel_bin),
        .rd_idx   (rd_idx),
        .rd_count (rd_count)
    );

    qdh_score_acc #(
        .NUM_BINS (NUM_BINS),
        .SCORE_W  (SCORE_W)
    ) u_score (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .add     (sample),
        .add_idx (sel_bin),
        .score   (score)
    );

endmodule

// File: rtl/qdh_checker.sv
module qdh_checker #(
    parameter int unsigned NUM_BINS = 16,
    parameter int unsigned SCORE_W  = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sample,
    input logic               clear,
    input logic [SCORE_W-1:0] score
);
    localparam logic [SCORE_W-1:0] SMAX = '1;
    localparam logic [SCORE_W:0]   WMAX = (SCORE_W+1)'(NUM_BINS);

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (score == '0));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample && !clear) |=> $stable(score));

    assert_score_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !clear && score != SMAX) |=> (score > $past(score)));

    assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !clear) |=> ({1'b0, score} <= {1'b0, $past(score)} + WMAX));

    assert_score_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (score == SMAX && !clear) |=> (score == SMAX));

endmodule

bind qdepth_hist_scorer qdh_checker #(
    .NUM_BINS (NUM_BINS),
    .SCORE_W  (SCORE_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (sample),
    .clear  (clear),
    .score  (score)
);

// File: tb/sim_qdepth_hist_scorer.sv
`timescale 1ns/1ps
module sim_qdepth_hist_scorer;
    localparam int NB  = 16;
    localparam int BW  = 6;
    localparam int SW  = 10;
    localparam int BMAX = (1 << BW) - 1;
    localparam int SMAX = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [19:0]   occ = '0;
    logic          sample = 1'b0;
    logic          clear = 1'b0;
    logic [3:0]    rd_idx = '0;
    logic [BW-1:0] rd_count;
    logic [SW-1:0] score;

    int checks = 0;
    int fails = 0;
    int pending = 0;
    bit done = 0;

    int exp_bins [NB];
    int exp_score = 0;

    typedef struct {
        bit    is_bin;
        int    idx;
        int    exp;
        string req;
    } item_t;
    item_t sb [$];

    always #5 clk = ~clk;

    qdepth_hist_scorer #(
        .BIN_W   (BW),
        .SCORE_W (SW)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .occ      (occ),
        .sample   (sample),
        .clear    (clear),
        .rd_idx   (rd_idx),
        .rd_count (rd_count),
        .score    (score)
    );

    // Reference model from the requirements
    function automatic int ref_bin(int a, int b, int c, int d);
        int m;
        m = (a + b + c + d) / 4;
        if (m > 15) m = 15;
        return m;
    endfunction

    task automatic push(bit is_bin, int idx, int exp, string req);
        item_t it;
        it.is_bin = is_bin;
        it.idx = idx;
        it.exp = exp;
        it.req = req;
        pending++;
        sb.push_back(it);
    endtask

    task automatic check_all(string req);
        push(1'b0, 0, exp_score, req);
        for (int b = 0; b < NB; b++) push(1'b1, b, exp_bins[b], req);
        wait (pending == 0);
    endtask

    task automatic op(int a, int b, int c, int d, bit smp, bit clr);
        int k;
        @(negedge clk);
        occ = {5'(d), 5'(c), 5'(b), 5'(a)};
        sample = smp;
        clear = clr;
        @(negedge clk);
        sample = 1'b0;
        clear = 1'b0;
        if (clr) begin
            for (int i = 0; i < NB; i++) exp_bins[i] = 0;
            exp_score = 0;
        end else if (smp) begin
            k = ref_bin(a, b, c, d);
            if (exp_bins[k] < BMAX) exp_bins[k]++;
            exp_score = exp_score + k + 1;
            if (exp_score > SMAX) exp_score = SMAX;
        end
    endtask

    // Monitor: pops expected items and compares them at the ports
    initial begin
        item_t it;
        int act;
        forever begin
            wait (sb.size() != 0);
            it = sb.pop_front();
            if (it.is_bin) rd_idx = 4'(it.idx);
            #1;
            act = it.is_bin ? int'(rd_count) : int'(score);
            checks++;
            if (act != it.exp) begin
                fails++;
                $display("FAIL %s %s[%0d] actual=%0d expected=%0d", it.req,
                         it.is_bin ? "bin" : "score", it.idx, act, it.exp);
            end
            pending--;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) exp_bins[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        op(0, 0, 0, 0, 1, 0);
        check_all("R2 R4 R5 zero depth");
        op(3, 4, 5, 6, 1, 0);
        check_all("R2 R5 mean 4");
        op(1, 2, 0, 0, 1, 0);
        check_all("R2 floor to bin 0");
        op(7, 7, 7, 8, 1, 0);
        check_all("R2 mean 7");
        op(15, 15, 14, 16, 1, 0);
        check_all("R2 mean exactly 15");
        op(16, 16, 16, 16, 1, 0);
        check_all("R3 full depth to top bin");
        op(31, 31, 31, 31, 1, 0);
        check_all("R3 clamp above 15");

        // r6_: inputs move without strobe
        op(9, 9, 9, 9, 0, 0);
        op(2, 30, 1, 17, 0, 0);
        check_all("R6 no strobe");

        // R10: index changes, no clock edge needed
        push(1'b1, 15, exp_bins[15], "R10 read top");
        push(1'b1, 4, exp_bins[4], "R10 read mid");
        wait (pending == 0);

        op(31, 31, 31, 31, 1, 1);
        check_all("R9 clear beats strobe");

        for (int n = 0; n < 70; n++) op(8, 8, 8, 8, 1, 0);
        check_all("R7 bin saturation");

        for (int n = 0; n < 60; n++) op(20, 20, 20, 20, 1, 0);
        check_all("R8 score saturation");

        op(0, 0, 0, 0, 0, 1);
        check_all("R9 clear alone");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule